// File: doc/BRIEF.md
# SPI Master/Slave Byte Controller

This block moves one 8-bit byte at a time over a four-wire serial link, full duplex. Software reaches it through three registers: control, status and data. As master it makes the serial clock from the system clock at one of four rates. It shifts the data byte out on its MOSI pin while it takes a byte in on MISO. Then it raises a completion flag. As slave it follows an external serial clock. The clock counts only while the active-low select is held low. The slave inputs are brought into the system-clock domain before their edges are found.

The byte that is shifted out is replaced by the byte that is shifted in. The received byte is copied into a read buffer. A write to the data register is not buffered. If it arrives while a byte is moving, it is refused and a collision flag is set. A master that sees its select input pulled low reports a mode fault and drops out of master mode, unless the select pin has been turned into a general-purpose output.

Top module: `spi_ctrl`

## Requirements
- R1: Register addresses are 0 for control, 1 for status and 2 for data. The control fields are bit0 enable, bit1 master, bit2 clock idle level, bit3 phase, bits 5:4 rate, bit6 select-as-output and bit7 select output level. Status bit0 is done, bit1 is write collision and bit2 is mode fault. After reset, control and status read 0 and sck_o, mosi_o and miso_o are 0.
- R2: With enable and master set, a write to the data register produces exactly 16 SCK transitions, which is 8 pulses. After them sck_o rests at the idle level from control bit2, and it also stays at that level while no transfer runs.
- R3: Each SCK half period lasts 1, 2, 8 or 16 system clocks for rate values 0, 1, 2 and 3, which divides the system clock by 2, 4, 16 or 32. The first transition comes one half period after the write cycle.
- R4: The master sends the most significant bit first. With phase 0 each MOSI bit is held through the leading SCK transition. With phase 1 it is held through the trailing one.
- R5: At the end of a master transfer, the data register reads the 8 bits taken from MISO on the sample transitions, MSB first.
- R6: Done (status bit0) is set at the end of each byte. A status read that sees it set, followed by a data register access, clears it.
- R7: A data write during a transfer is discarded and leaves the transfer intact. It sets the collision flag (status bit1), which clears the same way as done.
- R8: With enable and master set and select-as-output clear, ss_ni low sets the mode-fault flag (status bit2) and clears control bit1. The flag is cleared only by a status read that sees it, followed by a control write.
- R9: With control bit6 set, ss_ni low never sets the mode fault. ss_oe_o follows control bit6 and ss_o follows control bit7.
- R10: In slave mode, while ss_ni is low, the block takes a byte from mosi_i and sends the last written data byte on miso_o, MSB first, with the same phase rules as R4. The rate bits have no effect in slave mode, and sck_o stays idle.
- R11: A slave with phase 0 must see ss_ni go high between bytes. SCK edges after a completed byte, with ss_ni still low, are ignored.
- R12: A slave with phase 1 transfers several bytes in a row while ss_ni stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (drives the flag-clear sequence) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_ni | input | 1 | Select, active low |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_i | input | 1 | Serial data in (master) |
| sck_o | output | 1 | Serial clock out (master) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_o | output | 1 | Serial data out (slave) |
| ss_oe_o | output | 1 | Select pin used as output |
| ss_o | output | 1 | Select pin output level |

## Verification
The bench builds the block with its default 8-bit data width. Every combination of idle level, phase and rate is covered in master mode, with MISO looped back from MOSI both straight and inverted. This puts every divider setting and every sample-edge choice within reach of an exact check on edge spacing and bit order. In slave mode the bench acts as the external master at a slow half period, so the synchronizer delay stays inside each phase. It sweeps every mode and rate, and it also covers held-select framing for both phase values.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned HALF_W = 5;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic       ss_lvl;
    logic       ss_gpo;
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       en;
  } ctrl_t;

  // system clocks per SCK half period
  function automatic logic [HALF_W-1:0] half_cycles(input logic [1:0] rate);
    case (rate)
      2'd0:    half_cycles = HALF_W'(1);
      2'd1:    half_cycles = HALF_W'(2);
      2'd2:    half_cycles = HALF_W'(8);
      default: half_cycles = HALF_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
  parameter int unsigned HW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [HW-1:0] half_i,
  output logic          tick_o
);
  logic [HW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == half_i - HW'(1));
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + HW'(1);
  end
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl #(
  parameter int unsigned DATA_W = spi_pkg::DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              mosi_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              miso_o,
  output logic              ss_oe_o,
  output logic              ss_o
);
  import spi_pkg::*;

  localparam int unsigned EDGE_W = $clog2(2 * DATA_W);
  localparam int unsigned BIT_W  = $clog2(DATA_W);
  localparam int unsigned MSB    = DATA_W - 1;

  ctrl_t             ctrl_q;
  logic              done_q, wcol_q, modf_q;
  logic              seen_done_q, seen_wcol_q, seen_modf_q;
  logic [DATA_W-1:0] shreg_q, rdbuf_q, shift_val;
  logic              tx_q, sck_q, busy_q, framed_q;
  logic [EDGE_W-1:0] edge_q;
  logic [BIT_W-1:0]  bit_q;
  logic              sck_s, ss_s, mosi_s, sck_d_q, ss_d_q;
  logic              tick;

  spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ss_ni, mosi_i}),
    .q_o   ({sck_s, ss_s, mosi_s})
  );

  spi_clkdiv #(.HW(HALF_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_q),
    .half_i(half_cycles(ctrl_q.rate)),
    .tick_o(tick)
  );

  logic wr_ctrl, wr_data, rd_stat, data_acc;
  assign wr_ctrl  = wr_i && (addr_i == A_CTRL);
  assign wr_data  = wr_i && (addr_i == A_DATA);
  assign rd_stat  = rd_i && (addr_i == A_STAT);
  assign data_acc = (wr_i || rd_i) && (addr_i == A_DATA);

  logic master_mode, slave_mode, xfer_busy, write_ok, collide, modf_hit;
  assign master_mode = ctrl_q.en && ctrl_q.master;
  assign slave_mode  = ctrl_q.en && !ctrl_q.master;
  assign xfer_busy   = busy_q || (slave_mode && bit_q != '0);
  assign write_ok    = wr_data && !xfer_busy;
  assign collide     = wr_data && xfer_busy;
  assign modf_hit    = master_mode && !ctrl_q.ss_gpo && !ss_s;

  // master: sample on even transitions for phase 0, odd for phase 1
  logic m_sample, m_last;
  assign m_sample = tick && (edge_q[0] == ctrl_q.cpha);
  assign m_last   = tick && (edge_q == EDGE_W'(2 * DATA_W - 1));

  logic sck_rise, sck_fall, lead, trail, s_act, s_sample, s_drive, s_last, ss_fall;
  assign sck_rise = sck_s && !sck_d_q;
  assign sck_fall = !sck_s && sck_d_q;
  assign lead     = ctrl_q.cpol ? sck_fall : sck_rise;
  assign trail    = ctrl_q.cpol ? sck_rise : sck_fall;
  assign ss_fall  = !ss_s && ss_d_q;
  assign s_act    = slave_mode && !ss_s && framed_q;
  assign s_sample = s_act && (ctrl_q.cpha ? trail : lead);
  assign s_drive  = s_act && (ctrl_q.cpha ? lead : trail);
  assign s_last   = s_sample && (bit_q == BIT_W'(DATA_W - 1));

  assign shift_val = {shreg_q[MSB-1:0], master_mode ? miso_i : mosi_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      done_q      <= 1'b0;
      wcol_q      <= 1'b0;
      modf_q      <= 1'b0;
      seen_done_q <= 1'b0;
      seen_wcol_q <= 1'b0;
      seen_modf_q <= 1'b0;
      shreg_q     <= '0;
      rdbuf_q     <= '0;
      tx_q        <= 1'b0;
      sck_q       <= 1'b0;
      busy_q      <= 1'b0;
      framed_q    <= 1'b0;
      edge_q      <= '0;
      bit_q       <= '0;
      sck_d_q     <= 1'b0;
      ss_d_q      <= 1'b1;
    end else begin
      sck_d_q <= sck_s;
      ss_d_q  <= ss_s;

      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[7:0]);
      if (rd_stat) begin
        seen_done_q <= done_q;
        seen_wcol_q <= wcol_q;
        seen_modf_q <= modf_q;
      end
      if (data_acc) begin
        if (seen_done_q) done_q <= 1'b0;
        if (seen_wcol_q) wcol_q <= 1'b0;
        seen_done_q <= 1'b0;
        seen_wcol_q <= 1'b0;
      end
      if (wr_ctrl && seen_modf_q) begin
        modf_q      <= 1'b0;
        seen_modf_q <= 1'b0;
      end
      if (collide) wcol_q <= 1'b1;

      // master engine
      if (!busy_q) sck_q <= ctrl_q.cpol;
      if (write_ok) begin
        shreg_q <= wdata_i;
        tx_q    <= wdata_i[MSB];
        if (master_mode) begin
          busy_q <= 1'b1;
          edge_q <= '0;
        end
      end
      if (tick) begin
        sck_q  <= ~sck_q;
        edge_q <= edge_q + EDGE_W'(1);
        if (m_sample) shreg_q <= shift_val;
        else          tx_q    <= shreg_q[MSB];
        if (m_last) begin
          busy_q  <= 1'b0;
          rdbuf_q <= m_sample ? shift_val : shreg_q;
          done_q  <= 1'b1;
        end
      end

      // slave engine
      if (!slave_mode || ss_s) begin
        bit_q    <= '0;
        framed_q <= 1'b0;
      end else begin
        if (ss_fall) begin
          framed_q <= 1'b1;
          tx_q     <= shreg_q[MSB];
        end
        if (s_sample) begin
          shreg_q <= shift_val;
          bit_q   <= s_last ? '0 : bit_q + BIT_W'(1);
          if (s_last) begin
            rdbuf_q <= shift_val;
            done_q  <= 1'b1;
            if (!ctrl_q.cpha) framed_q <= 1'b0;
          end
        end
        if (s_drive) tx_q <= shreg_q[MSB];
      end

      if (modf_hit) begin
        modf_q        <= 1'b1;
        ctrl_q.master <= 1'b0;
        busy_q        <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[7:0] = ctrl_q;
      A_STAT:  rdata_o[2:0] = {modf_q, wcol_q, done_q};
      A_DATA:  rdata_o      = rdbuf_q;
      default: rdata_o      = '0;
    endcase
  end

  assign sck_o   = sck_q;
  assign mosi_o  = master_mode ? tx_q : 1'b0;
  assign miso_o  = slave_mode ? tx_q : 1'b0;
  assign ss_oe_o = ctrl_q.ss_gpo;
  assign ss_o    = ctrl_q.ss_lvl;
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       wr_i,
  input logic       sck_o,
  input logic       busy_i,
  input logic       cpol_i,
  input logic       master_i,
  input logic       modf_i,
  input logic       wcol_i,
  input logic       ss_gpo_i
);
  localparam int unsigned CW = $clog2(2 * DATA_W) + 1;

  logic [CW-1:0] tog_q;
  logic          sck_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q   <= '0;
      sck_d_q <= 1'b0;
    end else begin
      sck_d_q <= sck_o;
      if (!busy_i)              tog_q <= '0;
      else if (sck_o != sck_d_q) tog_q <= tog_q + CW'(1);
    end
  end

  // R2
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !$past(busy_i) && cpol_i == $past(cpol_i)) |-> sck_o == cpol_i);

  // R2
  pulse_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_i) && !modf_i) |-> (tog_q == CW'(2 * DATA_W - 1) && sck_o != sck_d_q));

  // R7
  wcol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd2 && busy_i) |=> wcol_i);

  // R8
  modf_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(modf_i) |-> !master_i);

  // R9
  gpo_no_modf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_gpo_i && !modf_i) |=> !modf_i);
endmodule

bind spi_ctrl spi_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .sck_o   (sck_o),
  .busy_i  (busy_q),
  .cpol_i  (ctrl_q.cpol),
  .master_i(ctrl_q.master),
  .modf_i  (modf_q),
  .wcol_i  (wcol_q),
  .ss_gpo_i(ctrl_q.ss_gpo)
);

// File: tb/spi_ctrl_tb.sv
module spi_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic sck_i = 1'b0, ss_n = 1'b1, mosi_i = 1'b0, miso_i;
  logic sck_o, mosi_o, miso_o, ss_oe_o, ss_o;
  logic loop_inv = 1'b0;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;
  assign miso_i = loop_inv ? ~mosi_o : mosi_o;

  spi_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sck_i(sck_i), .ss_ni(ss_n),
    .mosi_i(mosi_i), .miso_i(miso_i), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_o(miso_o), .ss_oe_o(ss_oe_o), .ss_o(ss_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic master_xfer(input bit cpol, input bit cpha, input logic [1:0] rate,
                             input logic [7:0] b, input bit inv);
    int half, tog, last, bad_iv;
    logic [7:0] cap, v;
    logic prev;
    half = (rate == 2'd0) ? 1 : (rate == 2'd1) ? 2 : (rate == 2'd2) ? 8 : 16;
    tog = 0; last = 0; bad_iv = 0; cap = '0;
    loop_inv = inv;
    reg_wr(2'd0, {2'b00, rate, cpha, cpol, 2'b11});
    wait_h(1);
    check(sck_o == cpol, "R2 idle level", sck_o, cpol);
    prev = sck_o;
    reg_wr(2'd2, b);
    for (int c = 1; c <= 16 * half + 8; c++) begin
      @(negedge clk);
      if (sck_o != prev) begin
        if (c - last != half) bad_iv++;
        if ((tog % 2) == int'(cpha)) cap = {cap[6:0], mosi_o};
        tog++; last = c; prev = sck_o;
      end
    end
    check(tog == 16, "R2 transition count", tog, 16);
    check(bad_iv == 0, "R3 half period", bad_iv, 0);
    check(cap == b, "R4 MOSI order", cap, b);
    check(sck_o == cpol, "R2 back to idle", sck_o, cpol);
    reg_rd(2'd1, v);
    check(v[0] == 1'b1, "R6 done set", v, 1);
    reg_rd(2'd2, v);
    check(v == (inv ? ~b : b), "R5 received byte", v, inv ? ~b : b);
    reg_rd(2'd1, v);
    check(v[0] == 1'b0, "R6 done cleared", v, 0);
  endtask

  task automatic slave_cfg(input bit cpol, input bit cpha, input logic [1:0] rate);
    ss_n = 1'b1; sck_i = cpol;
    wait_h(4);
    reg_wr(2'd0, {2'b00, rate, cpha, cpol, 2'b01});
    wait_h(4);
  endtask

  task automatic slave_byte(input bit cpol, input bit cpha, input logic [7:0] m,
                            input logic [7:0] s, input bit keep_ss, input string tag);
    logic [7:0] got, v;
    reg_wr(2'd2, s);
    if (ss_n) begin
      ss_n = 1'b0;
      if (!cpha) mosi_i = m[7];
      wait_h(H);
    end else if (!cpha) begin
      mosi_i = m[7];
      wait_h(H);
    end
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) begin
        got[i] = miso_o;
        sck_i = ~cpol; wait_h(H);
        sck_i = cpol;
        if (i > 0) mosi_i = m[i-1];
        wait_h(H);
      end else begin
        sck_i = ~cpol; mosi_i = m[i]; wait_h(H);
        got[i] = miso_o;
        sck_i = cpol; wait_h(H);
      end
    end
    if (!keep_ss) begin
      ss_n = 1'b1;
    end
    wait_h(H);
    check(got == s, {tag, " MISO byte"}, got, s);
    check(sck_o == cpol, "R10 sck_o idle in slave", sck_o, cpol);
    reg_rd(2'd1, v);
    check(v[0] == 1'b1, {tag, " done"}, v, 1);
    reg_rd(2'd2, v);
    check(v == m, {tag, " MOSI byte"}, v, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int idx;
    wait_h(3);
    rst_n = 1'b1;
    wait_h(2);

    // R1 reset state
    reg_rd(2'd0, v); check(v == 8'h00, "R1 ctrl reset", v, 0);
    reg_rd(2'd1, v); check(v == 8'h00, "R1 status reset", v, 0);
    check({sck_o, mosi_o, miso_o} == 3'b000, "R1 pins reset", {sck_o, mosi_o, miso_o}, 0);

    // R2..R6 master sweep
    idx = 0;
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 4; r++) begin
        master_xfer(m[1], m[0], r[1:0], 8'h3C + 8'(idx * 53), 1'b0);
        master_xfer(m[1], m[0], r[1:0], 8'hC1 ^ 8'(idx * 29), 1'b1);
        idx++;
      end
    end

    // R7 collision
    loop_inv = 1'b0;
    reg_wr(2'd0, 8'b0010_0011);
    reg_wr(2'd2, 8'h96);
    wait_h(20);
    reg_wr(2'd2, 8'h11);
    wait_h(16 * 8 + 10);
    reg_rd(2'd1, v); check(v[1:0] == 2'b11, "R7 wcol and done", v, 3);
    reg_rd(2'd2, v); check(v == 8'h96, "R7 transfer undisturbed", v, 8'h96);
    reg_rd(2'd1, v); check(v[1:0] == 2'b00, "R7 wcol cleared", v, 0);

    // R8 mode fault
    reg_wr(2'd0, 8'h03);
    ss_n = 1'b0; wait_h(6); ss_n = 1'b1; wait_h(4);
    reg_wr(2'd0, 8'h01);
    reg_rd(2'd1, v); check(v[2] == 1'b1, "R8 modf held without status read", v, 4);
    reg_rd(2'd0, v); check(v[1] == 1'b0, "R8 master cleared", v, 0);
    reg_wr(2'd0, 8'h01);
    reg_rd(2'd1, v); check(v[2] == 1'b0, "R8 modf cleared", v, 0);

    // R9 select as output
    reg_wr(2'd0, 8'b1100_0011);
    check(ss_oe_o == 1'b1 && ss_o == 1'b1, "R9 ss pins", {ss_oe_o, ss_o}, 3);
    ss_n = 1'b0; wait_h(6);
    reg_rd(2'd1, v); check(v[2] == 1'b0, "R9 no modf", v, 0);
    reg_rd(2'd0, v); check(v[1] == 1'b1, "R9 still master", v, 8'hC3);
    ss_n = 1'b1; wait_h(4);
    reg_wr(2'd0, 8'h00);

    // R10 slave sweep, all modes and rates
    idx = 0;
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 4; r++) begin
        slave_cfg(m[1], m[0], r[1:0]);
        slave_byte(m[1], m[0], 8'hA5 ^ 8'(idx * 37), 8'h5A + 8'(idx * 19), 1'b0, "R10");
        idx++;
      end
    end

    // R11 phase 0: select held low after a byte, further edges ignored
    for (int p = 0; p < 2; p++) begin
      slave_cfg(p[0], 1'b0, 2'd0);
      slave_byte(p[0], 1'b0, 8'h6D, 8'h72, 1'b1, "R11");
      for (int i = 0; i < 8; i++) begin
        mosi_i = i[0];
        sck_i = ~p[0]; wait_h(H);
        sck_i = p[0]; wait_h(H);
      end
      reg_rd(2'd1, v); check(v[0] == 1'b0, "R11 no second byte", v, 0);
      reg_rd(2'd2, v); check(v == 8'h6D, "R11 buffer kept", v, 8'h6D);
      ss_n = 1'b1; wait_h(H);
    end

    // R12 phase 1: three bytes under one select
    for (int p = 0; p < 2; p++) begin
      slave_cfg(p[0], 1'b1, 2'd2);
      for (int k = 0; k < 3; k++)
        slave_byte(p[0], 1'b1, 8'h19 + 8'(k * 71), 8'hE4 - 8'(k * 45), 1'b1, "R12");
      ss_n = 1'b1; wait_h(H);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule